// File: doc/BRIEF.md
# Multi-Mode Parallel Port Byte FIFO

This block is a 16-entry byte FIFO placed between a host register interface and the data path of a parallel port. A 3-bit mode input chooses its behaviour. It can act as a forward-only data FIFO for the standard port. It can act as a data FIFO for the extended-capability port, where the direction is chosen by a direction bit. It can act as a test FIFO that the host both fills and empties. It can also act as a read-only configuration register. A simple peripheral-side push/pop port takes the place of the port handshake.

The host reads and writes through single-cycle strobes on an 8-bit bus. The read result is registered and appears in the cycle after the read strobe. Occupancy is held in a register. The full, empty and service-interrupt flags follow that register, so they change one clock edge after the strobe that moves a byte. The service interrupt also depends on the current direction bit, combinationally. In test mode the byte at the head of the FIFO is shown on a separate port-data output. The peripheral sees the head byte on its own read bus at all times.

Top module: `pport_fifo`

## Requirements
- R1: In mode 3'b010, host writes are queued and peripheral pops remove bytes in write order. The byte at the head is shown on periph_rdata. Peripheral pushes and host reads do not change the occupancy or host_rdata.
- R2: In mode 3'b011 with dir=0, host writes are queued and peripheral pops drain them. With dir=1, peripheral pushes are queued and host reads return them in order on host_rdata, while host writes are ignored.
- R3: In mode 3'b110, host writes are queued and host reads return bytes from the head in write order, whatever the value of dir. Writing 44h, 33h, 22h reads back 44h, 33h, 22h. port_data shows the head byte in this mode and is 00h in every other mode.
- R4: A write while the FIFO holds 16 bytes is dropped. The occupancy stays at 16 and the stored bytes read back unchanged.
- R5: In mode 3'b110, a host read while the FIFO is empty returns the byte most recently read from the FIFO by the host, and the FIFO stays empty.
- R6: full is 1 exactly when 16 bytes are held. empty is 1 exactly when none are held. Both flags update at the edge that moves a byte.
- R7: In modes 3'b010, 3'b011 and 3'b110, svc_irq is 1 under either of two conditions. With the effective direction 0, it is 1 when the free space is at least WR_THR (8). With the effective direction 1, it is 1 when the occupancy is at least RD_THR (8). The effective direction is dir, except in mode 3'b010 where it is always 0. In all other modes svc_irq is 0.
- R8: In mode 3'b111, a host read returns 10h on host_rdata. Host writes have no effect, and the FIFO contents are untouched.
- R9: Changing mode or dir keeps the stored bytes and the occupancy.
- R10: After a synchronous reset the FIFO is empty, host_rdata is 00h, and the repeated-read byte is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Operating mode select |
| dir | input | 1 | Direction bit (0 toward peripheral, 1 toward host) |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| periph_push | input | 1 | Peripheral-side push strobe |
| periph_pop | input | 1 | Peripheral-side pop strobe |
| periph_wdata | input | 8 | Peripheral-side push data |
| periph_rdata | output | 8 | Head byte seen by the peripheral |
| port_data | output | 8 | Head byte shown in test mode, else 00h |
| full | output | 1 | FIFO holds 16 bytes |
| empty | output | 1 | FIFO holds no bytes |
| svc_irq | output | 1 | Service interrupt flag |

## Verification
A wrong occupancy count shows up in full, empty or svc_irq one edge after the strobe that corrupted it. The threshold sweeps walk every occupancy in both directions, so an off-by-one in a flag shows at the exact step where it flips. A bad pointer or a write that should have been dropped shows up as a wrong byte on host_rdata or port_data when the queue is later read back. A stale repeated-read byte appears on the first read of an empty test FIFO.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;
  typedef enum logic [2:0] {
    MODE_STD   = 3'b010,
    MODE_XDATA = 3'b011,
    MODE_TEST  = 3'b110,
    MODE_CFG   = 3'b111
  } mode_e;

  localparam logic [7:0] CFG_A_VALUE = 8'h10;
endpackage

// File: rtl/pfifo_ctrl.sv
module pfifo_ctrl
  import pfifo_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [2:0]   mode,
  input  logic         dir,
  input  logic         host_wr,
  input  logic         host_rd,
  input  logic         periph_push,
  input  logic         periph_pop,
  input  logic [W-1:0] host_wdata,
  input  logic [W-1:0] periph_wdata,
  output logic         push_req,
  output logic         pop_req,
  output logic [W-1:0] push_data,
  output logic         host_fifo_rd,
  output logic         cfg_rd,
  output logic         eff_dir,
  output logic         irq_en,
  output logic         show_head
);
  always_comb begin
    push_req     = 1'b0;
    pop_req      = 1'b0;
    push_data    = host_wdata;
    host_fifo_rd = 1'b0;
    cfg_rd       = 1'b0;
    eff_dir      = 1'b0;
    irq_en       = 1'b0;
    show_head    = 1'b0;
    case (mode)
      MODE_STD: begin
        push_req = host_wr;
        pop_req  = periph_pop;
        irq_en   = 1'b1;
      end
      MODE_XDATA: begin
        eff_dir = dir;
        irq_en  = 1'b1;
        if (!dir) begin
          push_req = host_wr;
          pop_req  = periph_pop;
        end else begin
          push_req     = periph_push;
          push_data    = periph_wdata;
          pop_req      = host_rd;
          host_fifo_rd = host_rd;
        end
      end
      MODE_TEST: begin
        push_req     = host_wr;
        pop_req      = host_rd;
        host_fifo_rd = host_rd;
        eff_dir      = dir;
        irq_en       = 1'b1;
        show_head    = 1'b1;
      end
      MODE_CFG: cfg_rd = host_rd;
      default: ;
    endcase
  end
endmodule

// File: rtl/pfifo_store.sv
module pfifo_store #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_req,
  input  logic         pop_req,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] head,
  output logic [CW-1:0] count,
  output logic         full,
  output logic         empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push_req && !full;
  assign do_pop  = pop_req && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
  assert_drop_when_full_R4: assert property (@(posedge clk) disable iff (rst)
    full && push_req && !pop_req |=> full && count == $past(count));
  assert_stay_empty_R5: assert property (@(posedge clk) disable iff (rst)
    empty && pop_req && !push_req |=> empty);
endmodule

// File: rtl/pfifo_irq.sv
module pfifo_irq #(
  parameter int DEPTH  = 16,
  parameter int WR_THR = 8,
  parameter int RD_THR = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          irq_en,
  input  logic          eff_dir,
  input  logic [CW-1:0] count,
  output logic          svc_irq
);
  logic room_ok, fill_ok;
  assign room_ok = (CW'(DEPTH) - count) >= CW'(WR_THR);
  assign fill_ok = count >= CW'(RD_THR);
  assign svc_irq = irq_en && (eff_dir ? fill_ok : room_ok);
endmodule

// File: rtl/pport_fifo.sv
module pport_fifo
  import pfifo_pkg::*;
#(
  parameter int W      = 8,
  parameter int DEPTH  = 16,
  parameter int WR_THR = 8,
  parameter int RD_THR = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   mode,
  input  logic         dir,
  input  logic         host_wr,
  input  logic         host_rd,
  input  logic [W-1:0] host_wdata,
  output logic [W-1:0] host_rdata,
  input  logic         periph_push,
  input  logic         periph_pop,
  input  logic [W-1:0] periph_wdata,
  output logic [W-1:0] periph_rdata,
  output logic [W-1:0] port_data,
  output logic         full,
  output logic         empty,
  output logic         svc_irq
);
  logic          push_req, pop_req, host_fifo_rd, cfg_rd, eff_dir, irq_en, show_head;
  logic [W-1:0]  push_data, head, last_q;
  logic [CW-1:0] count;

  pfifo_ctrl #(.W(W)) u_ctrl (
    .mode(mode), .dir(dir), .host_wr(host_wr), .host_rd(host_rd),
    .periph_push(periph_push), .periph_pop(periph_pop),
    .host_wdata(host_wdata), .periph_wdata(periph_wdata),
    .push_req(push_req), .pop_req(pop_req), .push_data(push_data),
    .host_fifo_rd(host_fifo_rd), .cfg_rd(cfg_rd), .eff_dir(eff_dir),
    .irq_en(irq_en), .show_head(show_head)
  );

  pfifo_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
    .push_data(push_data), .head(head), .count(count),
    .full(full), .empty(empty)
  );

  pfifo_irq #(.DEPTH(DEPTH), .WR_THR(WR_THR), .RD_THR(RD_THR)) u_irq (
    .irq_en(irq_en), .eff_dir(eff_dir), .count(count), .svc_irq(svc_irq)
  );

  assign periph_rdata = head;
  assign port_data    = show_head ? head : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
      last_q     <= '0;
    end else if (cfg_rd) begin
      host_rdata <= W'(CFG_A_VALUE);
    end else if (host_fifo_rd) begin
      if (empty) begin
        host_rdata <= last_q;
      end else begin
        host_rdata <= head;
        last_q     <= head;
      end
    end
  end

  assert_cfg_value_R8: assert property (@(posedge clk) disable iff (rst)
    mode == 3'b111 && host_rd |=> host_rdata == W'(CFG_A_VALUE));
  assert_empty_reread_R5: assert property (@(posedge clk) disable iff (rst)
    mode == 3'b110 && host_rd && empty |=> host_rdata == $past(last_q));
endmodule

// File: tb/pport_fifo_tb.sv
module pport_fifo_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode = 3'b110;
  logic       dir = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0, periph_push = 1'b0, periph_pop = 1'b0;
  logic [7:0] host_wdata = '0, periph_wdata = '0;
  logic [7:0] host_rdata, periph_rdata, port_data;
  logic       full, empty, svc_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] q[$];
  logic [7:0] lastb = 8'h00;

  always #2.5 clk = ~clk;

  pport_fifo u_dut (
    .clk(clk), .rst(rst), .mode(mode), .dir(dir),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .periph_push(periph_push), .periph_pop(periph_pop),
    .periph_wdata(periph_wdata), .periph_rdata(periph_rdata),
    .port_data(port_data), .full(full), .empty(empty), .svc_irq(svc_irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
    host_wr = 0; host_rd = 0; periph_push = 0; periph_pop = 0;
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic exp_svc();
    int c = q.size();
    logic d;
    if (mode != 3'b010 && mode != 3'b011 && mode != 3'b110) return 1'b0;
    d = (mode == 3'b010) ? 1'b0 : dir;
    return d ? (c >= 8) : ((16 - c) >= 8);
  endfunction

  task automatic chk_flags(string tag);
    chk({tag, " full R6"}, {7'd0, full}, {7'd0, q.size() == 16});
    chk({tag, " empty R6"}, {7'd0, empty}, {7'd0, q.size() == 0});
    chk({tag, " svc R7"}, {7'd0, svc_irq}, {7'd0, exp_svc()});
  endtask

  task automatic host_write(logic [7:0] v);
    host_wr = 1; host_wdata = v; tick();
  endtask

  task automatic test_read(string tag);
    logic [7:0] e;
    host_rd = 1; tick();
    if (q.size() > 0) begin e = q.pop_front(); lastb = e; end else e = lastb;
    chk(tag, host_rdata, e);
  endtask

  initial begin
    #(5 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    tick(); tick();
    rst = 0;
    // R10 reset state
    chk("R10 rdata", host_rdata, 8'h00);
    chk_flags("R10");

    // R4 R6 R7: test mode, dir=1, fill past full
    mode = 3'b110; dir = 1; #1;
    for (int i = 0; i < 18; i++) begin
      host_write(8'hA0 + 8'(i));
      if (q.size() < 16) q.push_back(8'hA0 + 8'(i));
      chk_flags("R4 fill");
    end
    chk("R3 port_data head", port_data, q[0]);

    // R9: direction change keeps contents
    dir = 0; #1;
    chk_flags("R9 dir change");
    for (int i = 0; i < 18; i++) begin
      test_read("R3 R4 R5 drain");
      chk_flags("R7 drain");
    end

    // R3 ordering example
    host_write(8'h44); q.push_back(8'h44);
    host_write(8'h33); q.push_back(8'h33);
    host_write(8'h22); q.push_back(8'h22);
    for (int i = 0; i < 3; i++) test_read("R3 order");

    // R8 config read; write ignored
    mode = 3'b111; #1;
    chk_flags("R7 cfg svc");
    host_write(8'h55);
    chk_flags("R8 write ignored");
    host_rd = 1; tick();
    chk("R8 cfg value", host_rdata, 8'h10);
    chk("R3 port_data off", port_data, 8'h00);

    // R5 empty reread gives last FIFO byte, not config value
    mode = 3'b110; #1;
    test_read("R5 reread");
    chk_flags("R5 stays empty");

    // R1 standard mode
    mode = 3'b010; dir = 1; #1;
    chk_flags("R7 std forces dir0");
    for (int i = 0; i < 10; i++) begin
      host_write(8'h10 + 8'(i)); q.push_back(8'h10 + 8'(i));
      chk_flags("R1 std fill");
    end
    periph_push = 1; periph_wdata = 8'hEE; tick();
    chk_flags("R1 periph push ignored");
    host_rd = 1; tick();
    chk("R1 host read ignored", host_rdata, lastb);
    chk_flags("R1 host read ignored");
    for (int i = 0; i < 10; i++) begin
      chk("R1 periph head", periph_rdata, q[0]);
      periph_pop = 1; tick(); void'(q.pop_front());
      chk_flags("R1 std drain");
    end

    // R2 extended mode dir=1
    mode = 3'b011; dir = 1; #1;
    for (int i = 0; i < 9; i++) begin
      periph_push = 1; periph_wdata = 8'hC0 + 8'(i); tick(); q.push_back(8'hC0 + 8'(i));
      chk_flags("R2 rev fill");
    end
    host_write(8'h77);
    chk_flags("R2 host write ignored");
    for (int i = 0; i < 9; i++) begin
      test_read("R2 rev read");
      chk_flags("R2 rev drain");
    end

    // R2 extended mode dir=0
    dir = 0; #1;
    for (int i = 0; i < 3; i++) begin host_write(8'h60 + 8'(i)); q.push_back(8'h60 + 8'(i)); end
    for (int i = 0; i < 3; i++) begin
      chk("R2 fwd head", periph_rdata, q[0]);
      periph_pop = 1; tick(); void'(q.pop_front());
      chk_flags("R2 fwd drain");
    end

    // R7 undefined mode
    mode = 3'b000; #1;
    chk({"R7 mode0"}, {7'd0, svc_irq}, 8'h00);

    // R10 reset clears last byte
    mode = 3'b110; #1;
    host_write(8'h99);
    rst = 1; tick(); rst = 0; q.delete(); lastb = 8'h00;
    chk("R10 rdata", host_rdata, 8'h00);
    chk_flags("R10 after reset");
    test_read("R10 last cleared");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule